// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the two-wire slave front end of a 2 KB byte-addressed non-volatile memory. It cleans up the raw clock and data lines, recognises bus start and stop events and decodes the control byte. It runs byte writes, page writes, word-address loads and the three kinds of read. It drives one open-drain enable: a 1 pulls the data line low. The non-volatile array and the page buffer that programs it sit outside the block. Each data byte the engine accepts reaches the buffer as a one-cycle valid strobe with an address and a data byte. A separate commit strobe tells the buffer when to program.

An 11-bit pointer holds the address. The three block-select bits of every acknowledged control byte set its upper bits. The word address of a write sets its lower eight bits. Reads take data through a synchronous read port, one cycle after the pointer. A `busy` input comes from the programming sequencer. While it is high, the engine acknowledges nothing. A master can therefore poll with a write control byte until it receives an acknowledge.

The state machine has ten states. `ST_IDLE` waits for a start. `ST_CTRL` receives the control byte. On a matching code it moves to `ST_CTRL_ACK`; otherwise it goes to `ST_WAIT`. `ST_CTRL_ACK` moves to `ST_RDATA` for a read or to `ST_WADDR` for a write. `ST_WADDR` goes to `ST_WADDR_ACK`, which goes to `ST_WDATA`. `ST_WDATA` and `ST_WDATA_ACK` then alternate for each data byte. While `busy` is high, every receive state goes to `ST_WAIT` instead of its acknowledge state. `ST_RDATA` shifts out eight bits and then goes to `ST_RACK`. `ST_RACK` returns to `ST_RDATA` when the master acknowledges and goes to `ST_WAIT` when it does not. From any state, a stop forces `ST_IDLE` and a start forces `ST_CTRL`.

Top module: `eep_serial_slave`

## Requirements
- R1: From any state, a start (data falling while the clock is high) enters control-byte reception with a cleared bit count. A stop (data rising while the clock is high) returns to idle. Bytes clocked in while idle are ignored.
- R2: The control byte arrives MSB first. Bits 7..4 must equal 1010 for an acknowledge, bits 3..1 select the block, and bit 0 = 1 selects a read. Any other code gets no acknowledge.
- R3: Each acknowledged control byte loads its block bits into pointer bits 10..8. The byte after a write control byte loads pointer bits 7..0.
- R4: An acknowledge holds `sda_oe` high from the clock fall after the eighth bit to the clock fall that ends the ninth clock. `sda_oe` changes only while the filtered clock is low, and it is low after reset.
- R5: While `busy` is high, no byte gets an acknowledge, and no data byte is handed to the buffer.
- R6: Each acknowledged write data byte produces a one-cycle `wr_valid` that carries the pointer as `wr_addr` and the byte as `wr_data`.
- R7: `wr_commit` pulses on a stop only if at least one data byte was handed over since the last start. A repeated start discards the write without a commit.
- R8: After each write data byte, only pointer bits 3..0 increment, so writes wrap inside a 16-byte page.
- R9: A read with no word-address load starts at the last accessed address plus one.
- R10: Read bytes go out MSB first and change only after a clock fall. After each byte the full 11-bit pointer increments, wrapping from 0x7FF to 0x000.
- R11: When the master does not acknowledge a read byte, the engine releases the data line and waits for a stop or start.
- R12: Each line passes through a two-flop synchroniser and a three-sample majority filter, so a pulse of one clock cycle on either line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | input | 1 | Programming cycle running; suppresses all acknowledges |
| wr_valid | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr | output | 11 | Target address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | Stop ended a write that carried data |
| rd_addr | output | 11 | Synchronous read address (the pointer) |
| rd_data | input | 8 | Read data, one cycle after `rd_addr` |

## Verification
The checker watches four things on every cycle. `sda_oe` may move only while the filtered clock is low. No acknowledge phase may begin in a cycle that follows a high `busy`. Each write strobe lasts a single cycle. Every start or stop must force the state machine into control reception or idle on the next cycle. The bench's bus transactions are needed for everything else: the code match, pointer loading from the block bits and word address, page wrap on writes, the full-space wrap on reads, current-address continuation, commit versus repeated-start discard, release after a master's not-acknowledge, and glitch rejection. Only the bench can show these, because they depend on data values and whole byte sequences.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } eep_state_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_line_filter.sv
module eep_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int WIN         = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int HALF = WIN / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [WIN-1:0]         win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            win_q  <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
            clean  <= ($countones(win_q) > HALF);
        end
    end
endmodule

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        scl_rise  = scl & ~scl_q;
        scl_fall  = ~scl & scl_q;
        start_det = scl & scl_q & sda_q & ~sda;
        stop_det  = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_blk,
    input  logic [ADDR_W-9:0] blk,
    input  logic              load_word,
    input  logic [7:0]        word,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            if (load_blk)
                ptr[ADDR_W-1:8] <= blk;
            if (load_word)
                ptr[7:0] <= word;
            if (inc_page)
                ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
            if (inc_full)
                ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    localparam int BLK_W  = ADDR_W - 8;
    localparam int N_LINE = 2;

    logic [N_LINE-1:0] line_raw, line_clean;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign line_raw = {scl_in, sda_in};
    assign scl_f    = line_clean[1];
    assign sda_f    = line_clean[0];

    for (genvar g = 0; g < N_LINE; g++) begin : g_line
        eep_line_filter #(.SYNC_STAGES(2), .WIN(3)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (line_raw[g]),
            .clean(line_clean[g])
        );
    end

    eep_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_f),
        .sda      (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    eep_state_e  state, next;
    logic [7:0]  shreg, txreg;
    logic [3:0]  cnt;
    logic        rw_q, mack, wrote;
    logic        byte_end, ctrl_ok, in_ack;
    logic        load_blk, load_word, inc_page, inc_full;
    logic [ADDR_W-1:0] ptr;

    assign byte_end = scl_fall && (cnt == 4'd8);
    assign ctrl_ok  = (shreg[7:4] == DEV_CODE) && !busy;

    eep_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_blk (load_blk),
        .blk      (shreg[BLK_W:1]),
        .load_word(load_word),
        .word     (shreg),
        .inc_page (inc_page),
        .inc_full (inc_full),
        .ptr      (ptr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    // next-state logic
    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:      next = ST_IDLE;
            ST_CTRL:      if (byte_end) next = ctrl_ok ? ST_CTRL_ACK : ST_WAIT;
            ST_CTRL_ACK:  if (scl_fall) next = rw_q ? ST_RDATA : ST_WADDR;
            ST_WADDR:     if (byte_end) next = busy ? ST_WAIT : ST_WADDR_ACK;
            ST_WADDR_ACK: if (scl_fall) next = ST_WDATA;
            ST_WDATA:     if (byte_end) next = busy ? ST_WAIT : ST_WDATA_ACK;
            ST_WDATA_ACK: if (scl_fall) next = ST_WDATA;
            ST_RDATA:     if (scl_fall && cnt == 4'd7) next = ST_RACK;
            ST_RACK:      if (scl_fall) next = mack ? ST_RDATA : ST_WAIT;
            ST_WAIT:      next = ST_WAIT;
            default:      next = ST_IDLE;
        endcase
        if (stop_det)       next = ST_IDLE;
        else if (start_det) next = ST_CTRL;
    end

    // outputs
    always_comb begin
        in_ack    = (state == ST_CTRL_ACK) || (state == ST_WADDR_ACK) ||
                    (state == ST_WDATA_ACK);
        sda_oe    = in_ack || ((state == ST_RDATA) && !txreg[7]);
        load_blk  = (state == ST_CTRL)  && byte_end && ctrl_ok;
        load_word = (state == ST_WADDR) && byte_end && !busy;
        inc_page  = (state == ST_WDATA) && byte_end && !busy;
        inc_full  = (state == ST_RDATA) && scl_fall && (cnt == 4'd7);
        wr_valid  = inc_page;
        wr_commit = stop_det && wrote;
    end

    assign wr_addr = ptr;
    assign wr_data = shreg;
    assign rd_addr = ptr;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            txreg <= '1;
            cnt   <= '0;
            rw_q  <= 1'b0;
            mack  <= 1'b0;
            wrote <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt   <= '0;
            txreg <= '1;
            wrote <= 1'b0;
        end else if (next == ST_RDATA && state != ST_RDATA) begin
            txreg <= rd_data;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_CTRL, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_f};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_end) begin
                        cnt <= '0;
                    end
                    if (load_blk) rw_q  <= shreg[0];
                    if (inc_page) wrote <= 1'b1;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        txreg <= {txreg[6:0], 1'b1};
                        cnt   <= (cnt == 4'd7) ? 4'd0 : cnt + 1'b1;
                    end
                end
                ST_RACK: begin
                    txreg <= '1;
                    if (scl_rise) mack <= !sda_f;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eep_serial_slave_chk.sv
module eep_serial_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sda_oe,
    input logic scl_lvl,
    input logic in_ack,
    input logic wr_valid,
    input logic start_det,
    input logic stop_det,
    input logic st_ctrl,
    input logic st_idle
);
    a_r4_oe_moves_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_oe) |-> !scl_lvl);

    a_r5_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> !$past(busy));

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    a_r1_start_to_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        start_det && !stop_det |=> st_ctrl);

    a_r1_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> st_idle);
endmodule

bind eep_serial_slave eep_serial_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sda_oe   (sda_oe),
    .scl_lvl  (scl_f),
    .in_ack   (in_ack),
    .wr_valid (wr_valid),
    .start_det(start_det),
    .stop_det (stop_det),
    .st_ctrl  (state == eep_pkg::ST_CTRL),
    .st_idle  (state == eep_pkg::ST_IDLE)
);

// File: tb/eep_serial_slave_bench.sv
module eep_serial_slave_bench;
    localparam int H = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
    logic sda_oe, wr_valid, wr_commit;
    logic [10:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    wire sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_fail = 0;
    int wcount = 0, ccount = 0;
    logic [10:0] wl_addr [0:31];
    logic [7:0]  wl_data [0:31];
    logic [7:0]  mem [0:2047];

    eep_serial_slave u_eep_serial_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] init_val(int a);
        return 8'(a * 7 + 3);
    endfunction

    initial for (int i = 0; i < 2048; i++) mem[i] = init_val(i);

    always @(posedge clk) begin
        rd_data <= mem[rd_addr];
        if (wr_valid) begin
            mem[wr_addr] <= wr_data;
            if (wcount < 32) begin
                wl_addr[wcount] <= wr_addr;
                wl_data[wcount] <= wr_data;
            end
            wcount <= wcount + 1;
        end
        if (wr_commit) ccount <= ccount + 1;
    end

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic m_start;
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic m_bit(input logic b, output logic s);
        sda_m = b; wt(H); scl_m = 1'b1; wt(H / 2);
        s = sda_line; wt(H / 2); scl_m = 1'b0; wt(2);
    endtask

    task automatic m_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(b[i], s);
        m_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic m_read(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, s);
            d[i] = s;
        end
        m_bit(!give_ack, s);
        sda_m = 1'b1;
    endtask

    // {control byte, busy, expected acknowledge}
    localparam logic [9:0] VEC [0:7] = '{
        {8'hA0, 1'b0, 1'b1}, {8'hAE, 1'b0, 1'b1}, {8'hB0, 1'b0, 1'b0},
        {8'h20, 1'b0, 1'b0}, {8'hA0, 1'b1, 1'b0}, {8'hAE, 1'b1, 1'b0},
        {8'hA2, 1'b0, 1'b1}, {8'h50, 1'b0, 1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int w0, c0;
        wt(5); rst_n = 1'b1; wt(10);
        chk("R4 reset oe", sda_oe, 0);
        chk("R6 reset valid", wr_valid, 0);

        // R2 R5: control byte table
        for (int v = 0; v < 8; v++) begin
            busy = VEC[v][1];
            m_start;
            m_byte(VEC[v][9:2], ack);
            m_stop;
            busy = 1'b0;
            chk("R2 R5 ctrl ack", ack, VEC[v][0]);
        end

        // R3 R6 R7: byte write at block 3, word 0x45
        w0 = wcount; c0 = ccount;
        m_start;
        m_byte(8'hA6, ack); chk("R4 ctrl ack", ack, 1);
        m_byte(8'h45, ack); chk("R4 addr ack", ack, 1);
        m_byte(8'h5A, ack); chk("R4 data ack", ack, 1);
        m_stop; wt(4);
        chk("R6 one strobe", wcount - w0, 1);
        chk("R3 write addr", wl_addr[w0], 11'h345);
        chk("R6 write data", wl_data[w0], 8'h5A);
        chk("R7 commit on stop", ccount - c0, 1);

        // R8: page wrap
        w0 = wcount;
        m_start;
        m_byte(8'hA0, ack); m_byte(8'h1E, ack);
        m_byte(8'h11, ack); m_byte(8'h22, ack); m_byte(8'h33, ack);
        m_stop; wt(4);
        chk("R8 count", wcount - w0, 3);
        chk("R8 addr0", wl_addr[w0], 11'h01E);
        chk("R8 addr1", wl_addr[w0 + 1], 11'h01F);
        chk("R8 addr2 wraps", wl_addr[w0 + 2], 11'h010);

        // R9: current-address read continues at 0x011
        m_start;
        m_byte(8'hA1, ack); chk("R2 read ctrl ack", ack, 1);
        m_read(1'b0, d);
        m_stop;
        chk("R9 current read", d, init_val(11'h011));

        // R10 R7 R11: random read with repeated start across a block edge
        w0 = wcount; c0 = ccount;
        m_start;
        m_byte(8'hA4, ack); m_byte(8'hFE, ack);
        m_start;
        m_byte(8'hA5, ack);
        m_read(1'b1, d); chk("R10 seq byte0", d, init_val(11'h2FE));
        m_read(1'b1, d); chk("R10 seq byte1", d, init_val(11'h2FF));
        m_read(1'b0, d); chk("R10 seq byte2", d, init_val(11'h300));
        wt(H);
        chk("R11 released after nack", sda_oe, 0);
        m_stop; wt(4);
        chk("R7 no commit on restart", ccount - c0, 0);
        chk("R7 no strobe on addr only", wcount - w0, 0);

        // R10: pointer wraps at top of space
        m_start;
        m_byte(8'hAE, ack); m_byte(8'hFF, ack);
        m_start;
        m_byte(8'hAF, ack);
        m_read(1'b1, d); chk("R10 top byte", d, init_val(11'h7FF));
        m_read(1'b0, d); chk("R10 wrap to zero", d, init_val(0));
        m_stop;

        // R5: busy rises before a data byte
        w0 = wcount; c0 = ccount;
        m_start;
        m_byte(8'hA0, ack); m_byte(8'h50, ack);
        busy = 1'b1;
        m_byte(8'h77, ack);
        m_stop;
        busy = 1'b0; wt(4);
        chk("R5 data nack", ack, 0);
        chk("R5 no strobe", wcount - w0, 0);
        chk("R5 no commit", ccount - c0, 0);

        // R1: start mid-byte resynchronises
        m_start;
        m_bit(1'b1, ack); m_bit(1'b0, ack); m_bit(1'b1, ack);
        m_start;
        m_byte(8'hA0, ack);
        m_stop;
        chk("R1 restart mid byte", ack, 1);

        // R1: byte without start is ignored
        m_byte(8'hA0, ack);
        chk("R1 idle ignores byte", ack, 0);
        m_stop;

        // R12: one-cycle clock glitch is filtered
        m_start;
        wt(5); scl_m = 1'b1; wt(1); scl_m = 1'b0; wt(5);
        m_byte(8'hA0, ack);
        m_stop;
        chk("R12 glitch ignored", ack, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule